// File: doc/BRIEF.md
# Four-Channel DMA Controller Core

This block is the register and addressing core of a four-channel DMA controller. Software programs it through a byte-wide register port with a 4-bit offset. Each channel holds a 16-bit address and a 16-bit count. Both are loaded and read one byte at a time through a single byte-order latch that all channels share. The core also holds a mode setting per channel, one mask bit and one request bit per channel, a status register that clears on read, and a stored command byte that has no effect on behaviour.

A transfer engine outside the block asks a channel for one beat at a time and states the direction, write or read. If the channel accepts the beat, the core returns a 24-bit address. The low 16 bits are the channel's current address. The high 8 bits come from a page register file of eight entries, which the engine reaches through a separate page port. After an accepted beat the channel steps its address up or down by one and takes one off its count. When the count wraps from 0x0000 to 0xFFFF, the channel sets its transfer-complete flag. While that flag is set, the channel refuses further beats.

The byte latch is a two-state machine with states LATCH_LO and LATCH_HI. It has three transitions:
- An access to a channel register moves it from LATCH_LO to LATCH_HI, or from LATCH_HI back to LATCH_LO.
- A clear-latch write returns it to LATCH_LO.
- A master-reset write returns it to LATCH_LO.

Top module: `dma4_core`

## Requirements
- R1: After reset every mask bit is 1 (mask_o = 4'hF), every transfer-complete flag is 1, every request bit is 0, the command byte is 0x00 and the byte latch is in LATCH_LO. A status read at offset 0x8 therefore returns 0x0F.
- R2: Offsets 0x0 to 0x7 address channel reg_off[2:1]. An even offset selects the address register and an odd offset selects the count register. In LATCH_LO an access touches bits 7:0 and in LATCH_HI it touches bits 15:8. Every such access, read or write, toggles the latch.
- R3: A write to offset 0xC puts the latch in LATCH_LO. A write to 0xE clears all four mask bits. A write to 0xD is a master reset: it puts the latch in LATCH_LO, sets every mask bit, sets every transfer-complete flag and clears every request bit.
- R4: A write to offset 0xA sets mask bit reg_wdata[1:0] to reg_wdata[2]. A write to 0xF loads all four mask bits from reg_wdata[3:0], with bit n going to channel n.
- R5: A write to offset 0x9 sets request bit reg_wdata[1:0] to reg_wdata[2].
- R6: A read at offset 0x8 returns the transfer-complete flags of channels 3..0 in bits 3:0 and the request bits in bits 7:4. After the read, all four transfer-complete flags are cleared.
- R7: A write to offset 0xB programs channel reg_wdata[1:0]. Bits 3:2 give the transfer type (0 verify, 1 write, 2 read, 3 invalid) and bit 5 selects address decrement. A write beat is accepted only with type 1 and a read beat only with type 2.
- R8: A channel whose transfer-complete flag is set refuses every beat (acc_ok = 0) and its address and count stay unchanged.
- R9: An accepted beat returns the current address on acc_addr[15:0]. The channel's address then moves by one, up or down as bit 5 of the mode selects, wrapping at 16 bits. The count decreases by one, and the transfer-complete flag is set when the count wraps to 0xFFFF.
- R10: Page port index 7, 3, 1, 2, 0, 4, 5, 6 write storage slots 0 to 7 in that order, and a page read at an index returns what was written at that index. Channel n drives acc_addr[23:16] from slot n.
- R11: A write to offset 0x8 stores the byte, and cfg_flags shows it from the next cycle.
- R12: A beat requested in a cycle where reg_wr or reg_rd is high is refused and leaves the channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_rd | input | 1 | Single-cycle register read strobe (ignored when reg_wr is high) |
| reg_off | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte, valid in the cycle of reg_rd |
| page_we | input | 1 | Page register write strobe |
| page_idx | input | 3 | Page port index for both write and read |
| page_wdata | input | 8 | Page write byte |
| page_rdata | output | 8 | Page byte stored at page_idx |
| acc_req | input | 1 | Beat request |
| acc_ch | input | 2 | Channel asked for a beat |
| acc_write | input | 1 | Beat direction: 1 write, 0 read |
| acc_ok | output | 1 | Beat accepted in this cycle |
| acc_addr | output | 24 | Page byte and current address of acc_ch |
| mask_o | output | 4 | Mask bits, one per channel |
| cfg_flags | output | 8 | Stored command byte |

## Verification
The hardest state to reach from the ports is a channel that accepts beats. Reset leaves every transfer-complete flag set, so the stimulus first reads status to clear those flags. It then programs a matching direction type and loads the count through the shared byte latch before any beat can succeed. The count wrap is reached by loading small counts, 2 and 1, and walking them through 0 to 0xFFFF. The refusal that follows is then observed and read back through the count bytes. The page slot order can only be seen by writing distinct bytes to all eight page indices and checking the page byte of beats on channels 1 and 3.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    typedef enum logic [1:0] {
        XF_VERIFY = 2'd0,
        XF_WRITE  = 2'd1,
        XF_READ   = 2'd2,
        XF_BAD    = 2'd3
    } xfer_e;

    typedef enum logic {
        LATCH_LO = 1'b0,
        LATCH_HI = 1'b1
    } latch_e;

    localparam logic [3:0] OFF_CMD_STAT = 4'h8;
    localparam logic [3:0] OFF_REQ      = 4'h9;
    localparam logic [3:0] OFF_MASK1    = 4'hA;
    localparam logic [3:0] OFF_MODE     = 4'hB;
    localparam logic [3:0] OFF_CLRFF    = 4'hC;
    localparam logic [3:0] OFF_MRST     = 4'hD;
    localparam logic [3:0] OFF_MCLR     = 4'hE;
    localparam logic [3:0] OFF_MALL     = 4'hF;

    // Port index to storage slot for the page file.
    function automatic logic [2:0] page_slot(input logic [2:0] idx);
        logic [2:0] s;
        case (idx)
            3'd7:    s = 3'd0;
            3'd3:    s = 3'd1;
            3'd1:    s = 3'd2;
            3'd2:    s = 3'd3;
            3'd0:    s = 3'd4;
            3'd4:    s = 3'd5;
            3'd5:    s = 3'd6;
            default: s = 3'd7;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we_lo,
    input  logic          addr_we_hi,
    input  logic          cnt_we_lo,
    input  logic          cnt_we_hi,
    input  logic [AW/2-1:0] wbyte,
    input  logic          mode_we,
    input  xfer_e         mode_xfer,
    input  logic          mode_dec,
    input  logic          mask_we,
    input  logic          mask_val,
    input  logic          req_we,
    input  logic          req_val,
    input  logic          master_rst,
    input  logic          tc_clear,
    input  logic          step,
    output logic [AW-1:0] addr_q,
    output logic [AW-1:0] cnt_q,
    output logic          mask_q,
    output logic          req_q,
    output logic          tc_q,
    output xfer_e         xfer_q,
    output logic          dec_q
);
    localparam int HB = AW / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            mask_q <= 1'b1;
            req_q  <= 1'b0;
            tc_q   <= 1'b1;
            xfer_q <= XF_VERIFY;
            dec_q  <= 1'b0;
        end else begin
            if (addr_we_lo) addr_q[HB-1:0]  <= wbyte;
            if (addr_we_hi) addr_q[AW-1:HB] <= wbyte;
            if (cnt_we_lo)  cnt_q[HB-1:0]   <= wbyte;
            if (cnt_we_hi)  cnt_q[AW-1:HB]  <= wbyte;
            if (step) begin
                addr_q <= dec_q ? addr_q - 1'b1 : addr_q + 1'b1;
                cnt_q  <= cnt_q - 1'b1;
            end
            if (mode_we) begin
                xfer_q <= mode_xfer;
                dec_q  <= mode_dec;
            end
            if (master_rst)   mask_q <= 1'b1;
            else if (mask_we) mask_q <= mask_val;
            if (master_rst)   req_q <= 1'b0;
            else if (req_we)  req_q <= req_val;
            if (master_rst)                tc_q <= 1'b1;
            else if (tc_clear)             tc_q <= 1'b0;
            else if (step && cnt_q == '0)  tc_q <= 1'b1;
        end
    end

    // R9
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> cnt_q == AW'($past(cnt_q) - 1'b1));

    // R9
    wrap_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == '0) |=> tc_q);

    // R3
    mrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_rst |=> (mask_q && tc_q && !req_q));

    // R6
    tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_clear && !master_rst) |=> !tc_q);

endmodule

// File: rtl/dma4_pages.sv
module dma4_pages
    import dma4_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NPG  = 8,
    parameter int NCH  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [$clog2(NPG)-1:0] idx,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          rdata,
    input  logic [$clog2(NCH)-1:0] ch_sel,
    output logic [DW-1:0]          ch_page
);
    localparam int IW = $clog2(NPG);

    logic [DW-1:0] slot_q [NPG];
    logic [IW-1:0] wslot;

    assign wslot = page_slot(idx);

    for (genvar s = 0; s < NPG; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (we && wslot == IW'(s))
                slot_q[s] <= wdata;
        end
    end

    assign rdata   = slot_q[wslot];
    assign ch_page = slot_q[IW'(ch_sel)];

endmodule

// File: rtl/dma4_core.sv
module dma4_core
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int NPG = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [3:0]             reg_off,
    input  logic [DW-1:0]          reg_wdata,
    output logic [DW-1:0]          reg_rdata,
    input  logic                   page_we,
    input  logic [$clog2(NPG)-1:0] page_idx,
    input  logic [DW-1:0]          page_wdata,
    output logic [DW-1:0]          page_rdata,
    input  logic                   acc_req,
    input  logic [$clog2(NCH)-1:0] acc_ch,
    input  logic                   acc_write,
    output logic                   acc_ok,
    output logic [3*DW-1:0]        acc_addr,
    output logic [NCH-1:0]         mask_o,
    output logic [DW-1:0]          cfg_flags
);
    localparam int AW  = 2 * DW;
    localparam int CW  = $clog2(NCH);

    latch_e latch_q, latch_d;

    logic           rd_en, any_acc, is_chreg, is_cnt;
    logic [CW-1:0]  sel_ch;
    logic           master_rst, clr_ff, tc_clear;

    logic [AW-1:0]  addr_v [NCH];
    logic [AW-1:0]  cnt_v  [NCH];
    logic [NCH-1:0] mask_v, req_v, tc_v, dec_v, step_v;
    xfer_e          xfer_v [NCH];
    logic [DW-1:0]  page_of_ch;

    assign rd_en      = reg_rd && !reg_wr;
    assign any_acc    = reg_wr || reg_rd;
    assign is_chreg   = !reg_off[3];
    assign is_cnt     = reg_off[0];
    assign sel_ch     = reg_off[2:1];
    assign master_rst = reg_wr && reg_off == OFF_MRST;
    assign clr_ff     = reg_wr && reg_off == OFF_CLRFF;
    assign tc_clear   = rd_en && reg_off == OFF_CMD_STAT;

    // Byte-order latch: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= LATCH_LO;
        else        latch_q <= latch_d;
    end

    // Byte-order latch: next state
    always_comb begin
        latch_d = latch_q;
        unique case (latch_q)
            LATCH_LO: begin
                if (master_rst || clr_ff)          latch_d = LATCH_LO;
                else if ((reg_wr || rd_en) && is_chreg) latch_d = LATCH_HI;
            end
            LATCH_HI: begin
                if (master_rst || clr_ff)          latch_d = LATCH_LO;
                else if ((reg_wr || rd_en) && is_chreg) latch_d = LATCH_LO;
            end
        endcase
    end

    // Command byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 cfg_flags <= '0;
        else if (reg_wr && reg_off == OFF_CMD_STAT) cfg_flags <= reg_wdata;
    end

    // Beat acceptance
    always_comb begin
        acc_ok = 1'b0;
        if (acc_req && !any_acc && !tc_v[acc_ch]) begin
            acc_ok = acc_write ? (xfer_v[acc_ch] == XF_WRITE)
                               : (xfer_v[acc_ch] == XF_READ);
        end
    end

    assign acc_addr = {page_of_ch, addr_v[acc_ch]};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit_addr, hit_cnt, mode_hit, mask_we, mask_val, req_hit;

        assign hit_addr = reg_wr && is_chreg && sel_ch == CW'(c) && !is_cnt;
        assign hit_cnt  = reg_wr && is_chreg && sel_ch == CW'(c) &&  is_cnt;
        assign mode_hit = reg_wr && reg_off == OFF_MODE && reg_wdata[1:0] == 2'(c);
        assign req_hit  = reg_wr && reg_off == OFF_REQ  && reg_wdata[1:0] == 2'(c);
        assign mask_we  = reg_wr && ((reg_off == OFF_MASK1 && reg_wdata[1:0] == 2'(c))
                                     || reg_off == OFF_MCLR || reg_off == OFF_MALL);
        assign mask_val = (reg_off == OFF_MASK1) ? reg_wdata[2] :
                          (reg_off == OFF_MALL)  ? reg_wdata[c] : 1'b0;
        assign step_v[c] = acc_ok && acc_ch == CW'(c);

        dma4_chan #(.AW(AW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .addr_we_lo (hit_addr && latch_q == LATCH_LO),
            .addr_we_hi (hit_addr && latch_q == LATCH_HI),
            .cnt_we_lo  (hit_cnt && latch_q == LATCH_LO),
            .cnt_we_hi  (hit_cnt && latch_q == LATCH_HI),
            .wbyte      (reg_wdata),
            .mode_we    (mode_hit),
            .mode_xfer  (xfer_e'(reg_wdata[3:2])),
            .mode_dec   (reg_wdata[5]),
            .mask_we    (mask_we),
            .mask_val   (mask_val),
            .req_we     (req_hit),
            .req_val    (reg_wdata[2]),
            .master_rst (master_rst),
            .tc_clear   (tc_clear),
            .step       (step_v[c]),
            .addr_q     (addr_v[c]),
            .cnt_q      (cnt_v[c]),
            .mask_q     (mask_v[c]),
            .req_q      (req_v[c]),
            .tc_q       (tc_v[c]),
            .xfer_q     (xfer_v[c]),
            .dec_q      (dec_v[c])
        );
    end

    assign mask_o = mask_v;

    dma4_pages #(.DW(DW), .NPG(NPG), .NCH(NCH)) u_pages (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (page_we),
        .idx     (page_idx),
        .wdata   (page_wdata),
        .rdata   (page_rdata),
        .ch_sel  (acc_ch),
        .ch_page (page_of_ch)
    );

    // Read-back mux
    always_comb begin
        logic [AW-1:0] word;
        word      = is_cnt ? cnt_v[sel_ch] : addr_v[sel_ch];
        reg_rdata = '0;
        if (rd_en) begin
            if (is_chreg) begin
                unique case (latch_q)
                    LATCH_LO: reg_rdata = word[DW-1:0];
                    LATCH_HI: reg_rdata = word[AW-1:DW];
                endcase
            end else if (reg_off == OFF_CMD_STAT) begin
                reg_rdata = DW'({req_v, tc_v});
            end
        end
    end

    // R2
    latch_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && !reg_off[3]) |=> latch_q != $past(latch_q));

    // R12
    no_beat_on_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> !acc_ok);

    // R8
    tc_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && tc_v[acc_ch]) |-> !acc_ok);

endmodule

// File: tb/dma4_core_test.sv
module dma4_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_off = '0;
    logic [7:0]  reg_wdata = '0, reg_rdata;
    logic        page_we = 1'b0;
    logic [2:0]  page_idx = '0;
    logic [7:0]  page_wdata = '0, page_rdata;
    logic        acc_req = 1'b0, acc_write = 1'b0, acc_ok;
    logic [1:0]  acc_ch = '0;
    logic [23:0] acc_addr;
    logic [3:0]  mask_o;
    logic [7:0]  cfg_flags;

    int errors = 0, checks = 0;
    bit done = 0;

    // Scoreboard of expected items
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    dma4_core uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .page_we(page_we), .page_idx(page_idx), .page_wdata(page_wdata),
        .page_rdata(page_rdata),
        .acc_req(acc_req), .acc_ch(acc_ch), .acc_write(acc_write),
        .acc_ok(acc_ok), .acc_addr(acc_addr),
        .mask_o(mask_o), .cfg_flags(cfg_flags)
    );

    task automatic push_exp(input string tag, input int v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic monitor(input int act);
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (act != e) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", t, act, e);
        end
    endtask

    task automatic wr(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_off = off; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] off, input string tag, input int e);
        @(negedge clk);
        reg_rd = 1'b1; reg_off = off;
        push_exp(tag, e);
        #5 monitor(int'(reg_rdata));
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pg_wr(input logic [2:0] i, input logic [7:0] d);
        @(negedge clk);
        page_we = 1'b1; page_idx = i; page_wdata = d;
        @(negedge clk);
        page_we = 1'b0;
    endtask

    task automatic pg_chk(input logic [2:0] i, input string tag, input int e);
        @(negedge clk);
        page_idx = i;
        push_exp(tag, e);
        #5 monitor(int'(page_rdata));
    endtask

    // A beat; expected acceptance and, when accepted, address
    task automatic beat(input logic [1:0] ch, input logic w, input string tag,
                        input bit exp_ok, input int exp_addr);
        @(negedge clk);
        acc_req = 1'b1; acc_ch = ch; acc_write = w;
        push_exp(tag, int'(exp_ok));
        if (exp_ok) push_exp(tag, exp_addr);
        #5;
        monitor(int'(acc_ok));
        if (exp_ok) monitor(int'(acc_addr));
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    task automatic port_chk(input string tag, input int act, input int e);
        push_exp(tag, e);
        monitor(act);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        port_chk("R1 mask", int'(mask_o), 'hF);
        port_chk("R1 cfg", int'(cfg_flags), 0);
        rd_chk(4'h8, "R1 status", 'h0F);
        rd_chk(4'h8, "R6 status cleared", 'h00);

        // R2 byte latch on channel 1
        wr(4'hC, 8'h00);
        wr(4'h2, 8'h34); wr(4'h2, 8'h12);
        wr(4'h3, 8'h02); wr(4'h3, 8'h00);
        rd_chk(4'h2, "R2 addr lo", 'h34);
        rd_chk(4'h2, "R2 addr hi", 'h12);
        rd_chk(4'h3, "R2 cnt lo", 'h02);
        rd_chk(4'h3, "R2 cnt hi", 'h00);
        wr(4'h2, 8'hAA);
        wr(4'hC, 8'h00);
        rd_chk(4'h2, "R3 clear latch lo", 'hAA);
        rd_chk(4'h2, "R3 clear latch hi", 'h12);

        // R7 / R9 / R8 channel 1 write, increment, page port 3
        wr(4'hB, 8'h05);
        pg_wr(3'd3, 8'h5A);
        beat(2'd1, 1'b0, "R7 read on write ch", 1'b0, 0);
        beat(2'd1, 1'b1, "R9 beat1", 1'b1, 'h5A12AA);
        beat(2'd1, 1'b1, "R9 beat2", 1'b1, 'h5A12AB);
        beat(2'd1, 1'b1, "R9 beat3", 1'b1, 'h5A12AC);
        beat(2'd1, 1'b1, "R8 refused after tc", 1'b0, 0);
        rd_chk(4'h8, "R9 tc status", 'h02);
        rd_chk(4'h3, "R9 cnt lo wrap", 'hFF);
        rd_chk(4'h3, "R9 cnt hi wrap", 'hFF);
        rd_chk(4'h2, "R9 addr lo", 'hAD);
        rd_chk(4'h2, "R9 addr hi", 'h12);

        // R7 / R9 channel 2 read, decrement, page port 1
        wr(4'h4, 8'h00); wr(4'h4, 8'h00);
        wr(4'h5, 8'h01); wr(4'h5, 8'h00);
        wr(4'hB, 8'h2A);
        pg_wr(3'd1, 8'h03);
        beat(2'd2, 1'b1, "R7 write on read ch", 1'b0, 0);
        beat(2'd2, 1'b0, "R9 dec beat1", 1'b1, 'h030000);
        beat(2'd2, 1'b0, "R9 dec beat2 wrap", 1'b1, 'h03FFFF);
        rd_chk(4'h4, "R9 dec addr lo", 'hFE);
        rd_chk(4'h4, "R9 dec addr hi", 'hFF);

        // R7 verify type refuses both directions
        beat(2'd0, 1'b1, "R7 verify write", 1'b0, 0);
        beat(2'd0, 1'b0, "R7 verify read", 1'b0, 0);

        // R3 / R4 masks
        wr(4'hE, 8'h00);
        @(negedge clk); port_chk("R3 mask clear", int'(mask_o), 'h0);
        wr(4'hA, 8'h06);
        @(negedge clk); port_chk("R4 single set", int'(mask_o), 'h4);
        wr(4'hF, 8'h09);
        @(negedge clk); port_chk("R4 load all", int'(mask_o), 'h9);
        wr(4'hA, 8'h00);
        @(negedge clk); port_chk("R4 single clear", int'(mask_o), 'h8);

        // R5 / R6 requests
        wr(4'h9, 8'h07);
        rd_chk(4'h8, "R5 req in status", 'h84);
        rd_chk(4'h8, "R6 tc cleared", 'h80);
        wr(4'h9, 8'h03);
        rd_chk(4'h8, "R5 req cleared", 'h00);

        // R3 master reset
        wr(4'h9, 8'h05);
        wr(4'h0, 8'h11);
        wr(4'hD, 8'h00);
        @(negedge clk); port_chk("R3 master mask", int'(mask_o), 'hF);
        rd_chk(4'h8, "R3 master status", 'h0F);
        wr(4'h0, 8'h22); wr(4'h0, 8'h33);
        wr(4'hC, 8'h00);
        rd_chk(4'h0, "R3 master latch lo", 'h22);
        rd_chk(4'h0, "R3 master latch hi", 'h33);

        // R11 command byte
        wr(4'h8, 8'hA5);
        @(negedge clk); port_chk("R11 cfg", int'(cfg_flags), 'hA5);

        // R10 page file
        for (int i = 0; i < 8; i++) pg_wr(3'(i), 8'(8'h10 + i));
        for (int i = 0; i < 8; i++) pg_chk(3'(i), "R10 page read", 'h10 + i);
        wr(4'hB, 8'h07);
        wr(4'h6, 8'h00); wr(4'h6, 8'h00);
        wr(4'h7, 8'h05); wr(4'h7, 8'h00);
        beat(2'd3, 1'b1, "R10 ch3 page slot", 1'b1, 'h120000);
        beat(2'd1, 1'b1, "R10 ch1 page slot", 1'b1, 'h1312AD);

        // R12 beat during register strobe
        @(negedge clk);
        reg_wr = 1'b1; reg_off = 4'hC; reg_wdata = 8'h00;
        acc_req = 1'b1; acc_ch = 2'd3; acc_write = 1'b1;
        #5 port_chk("R12 collision refused", int'(acc_ok), 0);
        @(negedge clk);
        reg_wr = 1'b0; acc_req = 1'b0;
        rd_chk(4'h7, "R12 cnt lo unchanged", 'h04);
        rd_chk(4'h7, "R12 cnt hi unchanged", 'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule